// File: doc/BRIEF.md
# Event Timer Global Registers and Main Counter

This block holds the shared state of a multi-channel event timer: a free-running 64-bit main counter, a read-only capability word pair, a two-bit global configuration and a per-channel interrupt status word. Software reaches all of it through a 32-bit memory-mapped port. Each 64-bit quantity is split into a low word and a high word at the next word offset. Addresses from 0x100 to 0x3FF belong to the channels. The block decodes them into a channel index and a register offset, forwards the access to the channel logic and returns that logic's read data.

The counter advances by one on each `tick_en` pulse, but only while the run bit is set. When run is cleared, the counter freezes at its current value and resumes from that value once run is set again. Either half of the counter can be loaded at any time. When run goes from 0 to 1, the block emits a one-cycle re-arm vector naming every implemented channel whose comparator is not idle. A status write produces a one-cycle acknowledge vector that the channels use to drop their level interrupts.

The global map is: 0x000 capability low, 0x004 capability high, 0x010 configuration, 0x014 configuration high, 0x020 status, 0x0F0 counter low, 0x0F4 counter high. Address bits [1:0] are ignored. Reads return data combinationally in the same cycle. Writes take effect at the clock edge.

Top module: `evt_timer_core`

## Requirements
- R1: The capability low word at 0x000 reads `{VENDOR, 16'hA001}` with (channels - 1) placed in bits [12:8]. The word at 0x004 reads TICK_FS, the tick period in femtoseconds. Writes to either word change nothing.
- R2: Configuration bit 0 (run) and bit 1 (legacy) can be written and read back, and they drive `run_en` and `legacy_en` from the cycle after the write. All other configuration bits read 0. The word at 0x014 reads 0 and ignores writes.
- R3: While `run_en` is 1, the counter increases by exactly one on each cycle with `tick_en` high. While `run_en` is 0, it holds its value.
- R4: A write to 0x0F0 or 0x0F4 replaces only the low or the high 32 bits of the counter, whatever the run state. A load takes priority over a tick in the same cycle. Both halves read back the current count.
- R5: Status bit i (at 0x020) is set by `ch_event[i]` for an implemented channel. A status write clears only the bits that are both written as 1 and currently set. `ch_ack` carries exactly those bits for the one cycle after the write.
- R6: An event and a clear of the same status bit in the same cycle leave the bit set, and the acknowledge for it is still issued.
- R7: A configuration write that takes run from 0 to 1 drives `ch_rearm` for one cycle with the implemented channels whose `ch_cmp_idle` bit is 0. `ch_rearm` is zero at all other times, including writes that keep run at 1.
- R8: For an address in 0x100..0x3FF, the channel index is (address - 0x100) / 32 and `ch_offset` is the word-aligned byte offset within the channel. For an implemented index, `ch_valid` is asserted and a read returns `ch_rdata`. For an index beyond the implemented count, the read returns 0 and `ch_valid` stays low.
- R9: The implemented channel count is NUM_CH clamped to the range from MIN_CH to the smaller of MAX_CH and 24. Status bits at and above that count stay 0.
- R10: After reset, the counter, the configuration and the status are 0. Unmapped global offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick strobe |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ch_valid | output | 1 | Access forwarded to an implemented channel |
| ch_write | output | 1 | Forwarded access is a write |
| ch_index | output | 5 | Channel index of the forwarded access |
| ch_offset | output | 5 | Byte offset inside the channel's 32-byte slot |
| ch_wdata | output | 32 | Forwarded write data |
| ch_rdata | input | 32 | Read data from the addressed channel |
| ch_event | input | 32 | Per-channel status set request |
| ch_cmp_idle | input | 32 | Per-channel flag: comparator is all ones |
| ch_ack | output | 32 | One-cycle status clear acknowledge per channel |
| ch_rearm | output | 32 | One-cycle re-arm request per channel |
| run_en | output | 1 | Global run/enable bit |
| legacy_en | output | 1 | Legacy routing mode bit |

## Verification
The bench pushes a loaded counter across the 32-bit carry with a single tick. An adder that kept two independent halves would leave the high word unchanged. It loads the counter halves while running and in the same cycle as a tick, so a design that let the increment win, or that touched the other half, would read back the wrong value. It raises an event on a status bit while clearing that bit, and it writes 1s to bits that are not set. A design that let the clear win, or acknowledged bits that were never set, would show up at `ch_ack` or on the status read. The bench also writes run=1 while run is already 1, probes the first and last slots around the implemented channel count, and checks the channel-count field of instances built with out-of-range counts, so that spurious re-arms, off-by-one window decoding and a missing clamp are each visible.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int ADDR_W = 10;
  localparam int WIN_CH = 24;
  localparam int CNT_W  = 64;
  localparam int STS_W  = 32;

  localparam logic [7:0] OFS_CAP_LO = 8'h00;
  localparam logic [7:0] OFS_CAP_HI = 8'h04;
  localparam logic [7:0] OFS_CFG_LO = 8'h10;
  localparam logic [7:0] OFS_CFG_HI = 8'h14;
  localparam logic [7:0] OFS_STS    = 8'h20;
  localparam logic [7:0] OFS_CNT_LO = 8'hF0;
  localparam logic [7:0] OFS_CNT_HI = 8'hF4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAP_LO, SEL_CAP_HI, SEL_CFG_LO, SEL_CFG_HI,
    SEL_STS, SEL_CNT_LO, SEL_CNT_HI, SEL_CHAN
  } reg_sel_e;

  function automatic int clamp_count(int req, int lo, int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  function automatic logic [STS_W-1:0] impl_mask(int n);
    logic [STS_W-1:0] m;
    m = '0;
    for (int i = 0; i < STS_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] cap_low_word(logic [15:0] vendor, int n);
    logic [31:0] fld;
    fld = (32'(n - 1) & 32'h1F) << 8;
    return {vendor, 16'hA001} | fld;
  endfunction

  function automatic logic [CNT_W-1:0] merge_half(logic [CNT_W-1:0] old,
                                                  logic [31:0] word, logic hi);
    return hi ? {word, old[31:0]} : {old[CNT_W-1:32], word};
  endfunction
endpackage

// File: rtl/etc_decode.sv
module etc_decode
  import etc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              ch_hit,
  output logic [4:0]        ch_idx,
  output logic [4:0]        ch_ofs
);
  logic [7:0] gofs;
  assign gofs = {addr[7:2], 2'b00};

  always_comb begin
    ch_idx = addr[9:5] - 5'd8;
    ch_ofs = {addr[4:2], 2'b00};
    ch_hit = 1'b0;
    sel    = SEL_NONE;
    if (addr[9:8] != 2'b00) begin
      if (int'(ch_idx) < NCH) begin
        ch_hit = 1'b1;
        sel    = SEL_CHAN;
      end
    end else begin
      case (gofs)
        OFS_CAP_LO: sel = SEL_CAP_LO;
        OFS_CAP_HI: sel = SEL_CAP_HI;
        OFS_CFG_LO: sel = SEL_CFG_LO;
        OFS_CFG_HI: sel = SEL_CFG_HI;
        OFS_STS:    sel = SEL_STS;
        OFS_CNT_LO: sel = SEL_CNT_LO;
        OFS_CNT_HI: sel = SEL_CNT_HI;
        default:    sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/etc_counter.sv
module etc_counter
  import etc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (wr_lo || wr_hi)
      count <= merge_half(count, wdata, wr_hi);
    else if (run && tick)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/etc_status.sv
module etc_status
  import etc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_in,
  input  logic             clr_wr,
  input  logic [STS_W-1:0] clr_data,
  output logic [STS_W-1:0] status,
  output logic [STS_W-1:0] clr_pulse
);
  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (i < NCH) begin : g_impl
      logic bit_q, ack_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
          ack_q <= 1'b0;
        end else begin
          ack_q <= clr_wr && clr_data[i] && bit_q;
          if (set_in[i])
            bit_q <= 1'b1;
          else if (clr_wr && clr_data[i])
            bit_q <= 1'b0;
        end
      end
      assign status[i]    = bit_q;
      assign clr_pulse[i] = ack_q;
    end else begin : g_none
      assign status[i]    = 1'b0;
      assign clr_pulse[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import etc_pkg::*;
#(
  parameter int          NUM_CH  = 4,
  parameter int          MIN_CH  = 3,
  parameter int          MAX_CH  = 24,
  parameter logic [15:0] VENDOR  = 16'h5A17,
  parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ch_valid,
  output logic              ch_write,
  output logic [4:0]        ch_index,
  output logic [4:0]        ch_offset,
  output logic [31:0]       ch_wdata,
  input  logic [31:0]       ch_rdata,
  input  logic [31:0]       ch_event,
  input  logic [31:0]       ch_cmp_idle,
  output logic [31:0]       ch_ack,
  output logic [31:0]       ch_rearm,
  output logic              run_en,
  output logic              legacy_en
);
  localparam int              TOP_LIM   = (MAX_CH > WIN_CH) ? WIN_CH : MAX_CH;
  localparam int              NCH       = clamp_count(NUM_CH, MIN_CH, TOP_LIM);
  localparam logic [STS_W-1:0] IMPL_MASK = impl_mask(NCH);
  localparam logic [31:0]     CAP_LO    = cap_low_word(VENDOR, NCH);

  reg_sel_e   sel;
  logic       ch_hit;
  logic [4:0] idx, ofs;

  etc_decode #(.NCH(NCH)) u_dec (
    .addr(bus_addr), .sel(sel), .ch_hit(ch_hit), .ch_idx(idx), .ch_ofs(ofs)
  );

  // named events
  logic bus_wr, cnt_wr_lo, cnt_wr_hi, cnt_wr, cfg_wr, sts_wr, en_rise;
  logic [1:0] cfg_q;
  assign bus_wr    = bus_valid && bus_write;
  assign cnt_wr_lo = bus_wr && (sel == SEL_CNT_LO);
  assign cnt_wr_hi = bus_wr && (sel == SEL_CNT_HI);
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;
  assign cfg_wr    = bus_wr && (sel == SEL_CFG_LO);
  assign sts_wr    = bus_wr && (sel == SEL_STS);
  assign en_rise   = cfg_wr && bus_wdata[0] && !cfg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= 2'b00;
    else if (cfg_wr) cfg_q <= bus_wdata[1:0];
  end
  assign run_en    = cfg_q[0];
  assign legacy_en = cfg_q[1];

  logic [31:0] rearm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rearm_q <= '0;
    else        rearm_q <= en_rise ? (~ch_cmp_idle & IMPL_MASK) : '0;
  end
  assign ch_rearm = rearm_q;

  logic [CNT_W-1:0] count;
  etc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_q[0]), .tick(tick_en),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(bus_wdata), .count(count)
  );

  logic [STS_W-1:0] status;
  etc_status #(.NCH(NCH)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_in(ch_event), .clr_wr(sts_wr),
    .clr_data(bus_wdata), .status(status), .clr_pulse(ch_ack)
  );

  assign ch_valid  = bus_valid && ch_hit;
  assign ch_write  = bus_write;
  assign ch_index  = idx;
  assign ch_offset = ofs;
  assign ch_wdata  = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_CAP_LO: bus_rdata = CAP_LO;
        SEL_CAP_HI: bus_rdata = TICK_FS;
        SEL_CFG_LO: bus_rdata = {30'd0, cfg_q};
        SEL_STS:    bus_rdata = status;
        SEL_CNT_LO: bus_rdata = count[31:0];
        SEL_CNT_HI: bus_rdata = count[63:32];
        SEL_CHAN:   bus_rdata = ch_rdata;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/etc_core_chk.sv
module etc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        run_en,
  input logic [63:0] count,
  input logic        cnt_wr,
  input logic [31:0] status,
  input logic [31:0] ch_ack,
  input logic [31:0] ch_rearm,
  input logic        ch_valid,
  input logic [4:0]  ch_index,
  input logic [5:0]  nch
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> (count == $past(count)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick_en && !cnt_wr) |=> (count == $past(count) + 64'd1));

  assert_ack_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack != 32'd0) |-> ((ch_ack & ~$past(status)) == 32'd0));

  assert_rearm_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rearm != 32'd0) |-> (run_en && !$past(run_en)));

  assert_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> ({1'b0, ch_index} < nch));

  assert_status_impl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status >> nch) == 32'd0));
endmodule

bind evt_timer_core etc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
  .count(count), .cnt_wr(cnt_wr), .status(status), .ch_ack(ch_ack),
  .ch_rearm(ch_rearm), .ch_valid(ch_valid), .ch_index(ch_index),
  .nch(6'(NCH))
);

// File: tb/test_evt_timer_core.sv
`timescale 1ns/1ps
module test_evt_timer_core;
  localparam logic [15:0] VEND = 16'h5A17;
  localparam logic [31:0] TFS  = 32'd10_000_000;
  localparam int          NCH  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, tick_en, bus_valid, bus_write;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, ch_rdata, ch_event, ch_cmp_idle;
  logic        ch_valid, ch_write, run_en, legacy_en;
  logic [4:0]  ch_index, ch_offset;
  logic [31:0] ch_wdata, ch_ack, ch_rearm;

  evt_timer_core i_evt_timer_core (
    .clk, .rst_n, .tick_en, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_rdata, .ch_valid, .ch_write, .ch_index, .ch_offset, .ch_wdata,
    .ch_rdata, .ch_event, .ch_cmp_idle, .ch_ack, .ch_rearm, .run_en, .legacy_en
  );

  // clamp instances (R9)
  logic [31:0] hi_rd, lo_rd, d_w0, d_w1, d_a0, d_a1, d_r0, d_r1;
  logic        d_v0, d_v1, d_wr0, d_wr1, d_e0, d_e1, d_l0, d_l1;
  logic [4:0]  d_i0, d_i1, d_o0, d_o1;
  evt_timer_core #(.NUM_CH(30)) i_hi (
    .clk, .rst_n, .tick_en, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_rdata(hi_rd), .ch_valid(d_v0), .ch_write(d_wr0), .ch_index(d_i0),
    .ch_offset(d_o0), .ch_wdata(d_w0), .ch_rdata, .ch_event, .ch_cmp_idle,
    .ch_ack(d_a0), .ch_rearm(d_r0), .run_en(d_e0), .legacy_en(d_l0)
  );
  evt_timer_core #(.NUM_CH(1)) i_lo (
    .clk, .rst_n, .tick_en, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_rdata(lo_rd), .ch_valid(d_v1), .ch_write(d_wr1), .ch_index(d_i1),
    .ch_offset(d_o1), .ch_wdata(d_w1), .ch_rdata, .ch_event, .ch_cmp_idle,
    .ch_ack(d_a1), .ch_rearm(d_r1), .run_en(d_e1), .legacy_en(d_l1)
  );

  int total = 0, bad = 0;
  logic [63:0] m_cnt;
  logic [1:0]  m_cfg;
  logic [31:0] m_sts;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cap_lo(int n);
    return {VEND, 16'hA001} | (32'(n - 1) << 8);
  endfunction

  function automatic string tag_of(logic [9:0] a);
    if (a[9:8] != 2'b00) return "R8 channel read";
    case ({a[7:2], 2'b00})
      8'h00, 8'h04: return "R1 capability read";
      8'h10, 8'h14: return "R2 config read";
      8'h20:        return "R5 status read";
      8'hF0, 8'hF4: return "R4 counter read";
      default:      return "R10 unmapped read";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [9:0] a, logic [31:0] chr);
    logic [4:0] ix;
    ix = a[9:5] - 5'd8;
    if (a[9:8] != 2'b00) return (ix < 5'(NCH)) ? chr : 32'd0;
    case ({a[7:2], 2'b00})
      8'h00:   return cap_lo(NCH);
      8'h04:   return TFS;
      8'h10:   return {30'd0, m_cfg};
      8'h20:   return m_sts;
      8'hF0:   return m_cnt[31:0];
      8'hF4:   return m_cnt[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(input logic v, input logic w, input logic [9:0] a,
                     input logic [31:0] d, input logic t, input logic [31:0] ev,
                     input logic [31:0] idle, input logic [31:0] chr);
    logic glob, inr, wr;
    logic [7:0] off;
    logic [4:0] ix;
    logic [63:0] n_cnt;
    logic [31:0] clr, e_ack, e_rearm;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    tick_en = t; ch_event = ev; ch_cmp_idle = idle; ch_rdata = chr;
    #1;
    glob = (a[9:8] == 2'b00);
    off  = {a[7:2], 2'b00};
    ix   = a[9:5] - 5'd8;
    inr  = !glob && (ix < 5'(NCH));
    wr   = v && w;
    chk("R8 ch_valid", ch_valid, v && inr);
    if (v && inr) begin
      chk("R8 ch_index", ch_index, ix);
      chk("R8 ch_offset", ch_offset, {a[4:2], 2'b00});
    end
    if (v && !w) begin
      chk(tag_of(a), bus_rdata, exp_read(a, chr));
      if (a == 10'h000) begin
        chk("R9 clamp to maximum", hi_rd, cap_lo(24));
        chk("R9 clamp to minimum", lo_rd, cap_lo(3));
      end
    end
    if (wr && glob && off == 8'hF0)      n_cnt = {m_cnt[63:32], d};
    else if (wr && glob && off == 8'hF4) n_cnt = {d, m_cnt[31:0]};
    else if (m_cfg[0] && t)              n_cnt = m_cnt + 64'd1;
    else                                 n_cnt = m_cnt;
    clr     = (wr && glob && off == 8'h20) ? d : 32'd0;
    e_ack   = clr & m_sts;
    e_rearm = (wr && glob && off == 8'h10 && d[0] && !m_cfg[0]) ? (~idle & 32'hF) : 32'd0;
    @(posedge clk);
    #1;
    m_cnt = n_cnt;
    m_sts = (m_sts & ~clr) | (ev & 32'hF);
    if (wr && glob && off == 8'h10) m_cfg = d[1:0];
    chk("R7 rearm vector", ch_rearm, e_rearm);
    chk("R5 ack vector", ch_ack, e_ack);
    chk("R2 run_en", run_en, m_cfg[0]);
    chk("R2 legacy_en", legacy_en, m_cfg[1]);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0, 0, 32'hFFFF_FFFF, 0);
  endtask
  task automatic rd(input logic [9:0] a);
    cyc(1, 0, a, 0, 0, 0, 32'hFFFF_FFFF, 32'hC0DE_0000 | 32'(a));
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tick_en = 0; bus_valid = 0; bus_write = 0; bus_addr = 0;
    bus_wdata = 0; ch_rdata = 0; ch_event = 0; ch_cmp_idle = 0;
    m_cnt = 0; m_cfg = 0; m_sts = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R10 reset state, R1 capability
    rd(10'h0F0); rd(10'h0F4); rd(10'h010); rd(10'h020); rd(10'h000); rd(10'h004);
    rd(10'h008); rd(10'h0FC);
    // R1 writes ignored, R2 reserved bits and high word
    wr(10'h000, 32'h1234_5678); wr(10'h004, 32'hFFFF_FFFF); rd(10'h000); rd(10'h004);
    wr(10'h014, 32'hFFFF_FFFF); rd(10'h014); wr(10'h010, 32'hFFFF_FFFC); rd(10'h010);
    // R3 hold while stopped, then count
    ticks(5); rd(10'h0F0);
    cyc(1, 1, 10'h010, 32'h1, 0, 0, 32'h0000_0005, 0);  // R7 rearm channels 1 and 3
    ticks(7); rd(10'h0F0);
    wr(10'h010, 32'h3); rd(10'h010);                     // R7 no rearm while running
    wr(10'h010, 32'h0); ticks(4); rd(10'h0F0);            // R3 frozen
    cyc(1, 1, 10'h010, 32'h1, 0, 0, 32'hFFFF_FFFF, 0);   // R7 all idle -> none
    ticks(2); rd(10'h0F0);
    // R4 carry across halves, load beats tick
    cyc(1, 1, 10'h0F0, 32'hFFFF_FFFF, 1, 0, 32'hFFFF_FFFF, 0);
    cyc(1, 1, 10'h0F4, 32'h0000_0001, 1, 0, 32'hFFFF_FFFF, 0);
    rd(10'h0F0); rd(10'h0F4); ticks(1); rd(10'h0F0); rd(10'h0F4);
    // R5 status set and selective clear, R9 unimplemented bits
    cyc(0, 0, 0, 0, 0, 32'hFFFF_FFF5, 32'hFFFF_FFFF, 0); rd(10'h020);
    wr(10'h020, 32'hFFFF_FFF2); rd(10'h020);
    // R6 event and clear collide
    cyc(0, 0, 0, 0, 0, 32'h0000_0002, 32'hFFFF_FFFF, 0);
    cyc(1, 1, 10'h020, 32'h2, 0, 32'h2, 32'hFFFF_FFFF, 0); rd(10'h020);
    // R8 channel window edges
    rd(10'h100); rd(10'h164); rd(10'h17C); rd(10'h180); rd(10'h3FC);
    cyc(1, 1, 10'h188, 32'hAAAA_5555, 0, 0, 32'hFFFF_FFFF, 0);
    cyc(1, 1, 10'h128, 32'hAAAA_5555, 0, 0, 32'hFFFF_FFFF, 0);

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [9:0] a;
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h010; 3: a = 10'h014;
        4: a = 10'h020; 5: a = 10'h0F0; 6: a = 10'h0F4; 7: a = 10'h0A8;
        default: a = 10'h100 + 10'($urandom_range(0, 767));
      endcase
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom(),
          $urandom_range(0, 1) == 1, $urandom() & $urandom() & $urandom(),
          $urandom(), $urandom());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule